// File: doc/BRIEF.md
# Sampled Input Noise Filter

This block cleans an asynchronous external signal, such as an interrupt line, a timer input or a conversion trigger, before its edges are acted on. The raw pin first crosses into the system clock domain through a two-flop synchronizer. A prescaler then issues one-clock sampling strobes at one of four rates. On each strobe the synchronized level is shifted into a short history. The filtered level only takes a new value once that value has appeared on three strobes in a row. Shorter excursions are discarded as noise.

Each change of the filtered level produces a registered one-clock rise or fall pulse. A two-bit edge select decides which of these changes also raise a one-clock interrupt request. Because the sampling period can be one clock or hundreds of clocks, the same agreement rule can reject glitches a few clocks long or disturbances lasting several hundred clocks.

Top module: `pin_noise_filter`

## Requirements
- R1: While reset is asserted (rst_n low), level_o, rise_o, fall_o and irq_o are 0, the sample history is 0 and the prescaler count is cleared.
- R2: The pin passes two synchronizer flops, and each strobe shifts the synchronized level into the history. With rate_sel 00, a pin change driven before a clock edge still shows the old level_o after four rising edges and the new level after the fifth.
- R3: A pin excursion lasting 2 sampling periods or less never changes level_o. One lasting 3 sampling periods or more always changes it. This holds at every rate.
- R4: rate_sel selects the strobe period: 00 every clock, 01 every 64 clocks, 10 every 128 clocks, 11 every 256 clocks. At a divided period D, level_o follows a stable pin change after between 2D+3 and 3D+2 rising edges.
- R5: A change of rate_sel clears the prescaler, and no strobe occurs in that cycle. The first strobe at the new period D comes D+1 edges after the change, so a pin change made together with it reaches level_o after exactly 3D+1 edges. A rate change alone never produces a rise or fall.
- R6: rise_o and fall_o are registered one-clock pulses. They go high in the same cycle that level_o becomes 1 (rise) or 0 (fall), and low in the next cycle.
- R7: edge_sel selects which edges raise the request: bit 0 enables rising edges and bit 1 enables falling edges (00 none, 01 rising, 10 falling, 11 both). irq_o is a one-clock pulse that coincides with the selected rise_o or fall_o.
- R8: rise_o and fall_o are never high together, and irq_o is never high outside a selected edge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous pin |
| rate_sel | input | 2 | Sampling period select |
| edge_sel | input | 2 | Request edge select |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-clock rising edge pulse |
| fall_o | output | 1 | One-clock falling edge pulse |
| irq_o | output | 1 | One-clock interrupt request pulse |

## Verification
A change of sampling rate can fall in the same cycle as a pin transition. The prescaler restart and the history shift then both act on that one change. The bench provokes this by writing a new divided rate and the new pin level on the same falling edge. It then requires the filtered level to change on exactly edge 3D+1 of the new period, neither earlier nor later. A separate rate change with a quiet pin must leave the rise and fall counts at zero.

// File: rtl/pin_noise_filter.sv
module pin_noise_filter #(
  parameter int DIV_A       = 64,
  parameter int DIV_B       = 128,
  parameter int DIV_C       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] rate_sel,
  input  logic [1:0] edge_sel,
  output logic       level_o,
  output logic       rise_o,
  output logic       fall_o,
  output logic       irq_o
);
  localparam int CNT_W = $clog2(DIV_C);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q, lim;
  logic [1:0]             rate_q, hist_q;
  logic                   level_q, rise_q, fall_q, irq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};

  wire pin_s = sync_q[SYNC_STAGES-1];

  always_comb
    case (rate_sel)
      2'd1:    lim = CNT_W'(DIV_A - 1);
      2'd2:    lim = CNT_W'(DIV_B - 1);
      2'd3:    lim = CNT_W'(DIV_C - 1);
      default: lim = '0;
    endcase

  wire restart = rate_q != rate_sel;
  wire strobe  = !restart && (cnt_q == lim);
  wire agree   = strobe && pin_s == hist_q[0] && pin_s == hist_q[1] && pin_s != level_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rate_q <= 2'd0;
      cnt_q  <= '0;
    end else begin
      rate_q <= rate_sel;
      cnt_q  <= (restart || cnt_q == lim) ? '0 : cnt_q + CNT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist_q  <= 2'b00;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (strobe) hist_q <= {hist_q[0], pin_s};
      if (agree)  level_q <= pin_s;
      rise_q <= agree && pin_s;
      fall_q <= agree && !pin_s;
      irq_q  <= agree && (pin_s ? edge_sel[0] : edge_sel[1]);
    end

  assign level_o = level_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign irq_o   = irq_q;

  p_level_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> $past(strobe));

  p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(hist_q));

  p_rise_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);

  p_rise_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (level_q && !$past(level_q)));

  p_fall_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!level_q && $past(level_q)));

  p_irq_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ((rise_q && $past(edge_sel[0])) || (fall_q && $past(edge_sel[1]))));

  p_restart_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != rate_q) |=> (cnt_q == '0));
endmodule

// File: tb/pin_noise_filter_bench.sv
module pin_noise_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DA = 64, DB = 128, DC = 256;

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0;
  logic [1:0] rate = 2'd0, esel = 2'd3;
  logic level, rise, fall, irq;
  int tests = 0, fails = 0;
  int n_rise = 0, n_fall = 0, n_irq = 0, n_bad = 0;

  pin_noise_filter #(.DIV_A(DA), .DIV_B(DB), .DIV_C(DC)) u_pin_noise_filter (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .rate_sel(rate), .edge_sel(esel),
    .level_o(level), .rise_o(rise), .fall_o(fall), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    if (rst_n) begin
      n_rise += int'(rise);
      n_fall += int'(fall);
      n_irq  += int'(irq);
      if (irq != ((rise & esel[0]) | (fall & esel[1]))) n_bad++;
      if (rise && fall) n_bad++;
    end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(string req, int act, int lo, int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic clear_counts();
    @(posedge clk);
    n_rise = 0; n_fall = 0; n_irq = 0;
    @(negedge clk);
  endtask

  function automatic int div_of(int r);
    return r == 1 ? DA : r == 2 ? DB : r == 3 ? DC : 1;
  endfunction

  task automatic pulse(string req, int w, int d);
    int exp;
    exp = (w >= 3 * d) ? 1 : 0;
    clear_counts();
    pin = 1'b1;
    step(w);
    pin = 1'b0;
    step(4 * d + 8);
    check(req, n_rise, exp);
    check(req, n_fall, exp);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(3);
    check("R1 level", int'(level), 0);
    check("R1 pulses", int'(rise | fall | irq), 0);
    rst_n = 1'b1;
    step(4);

    // R2 exact latency at the undivided rate, both directions
    pin = 1'b1;
    step(4);
    check("R2 rise early", int'(level), 0);
    step(1);
    check("R2 rise", int'(level), 1);
    check("R6 rise pulse", int'(rise), 1);
    check("R7 irq rise", int'(irq), 1);
    step(1);
    check("R6 rise width", int'(rise), 0);
    pin = 1'b0;
    step(4);
    check("R2 fall early", int'(level), 1);
    step(1);
    check("R2 fall", int'(level), 0);
    check("R6 fall pulse", int'(fall), 1);
    step(1);
    check("R6 fall width", int'(fall), 0);
    step(4);

    // R3 width sweep at rate 00
    for (int w = 1; w <= 6; w++) pulse("R3 rate00", w, 1);

    // R7 edge select sweep
    for (int s = 0; s < 4; s++) begin
      esel = 2'(s);
      clear_counts();
      pin = 1'b1; step(6); pin = 1'b0; step(12);
      check("R7 irq count", n_irq, (s & 1) + ((s >> 1) & 1));
      check("R7 edges", n_rise + n_fall, 2);
    end
    esel = 2'd3;

    // R4 divided rates: latency window and R3 widths
    for (int r = 1; r < 4; r++) begin
      int d, n;
      d = div_of(r);
      rate = 2'(r);
      step(d + 4);
      pin = 1'b1;
      n = 0;
      do begin step(1); n++; end while (level != 1'b1 && n < 4 * d);
      check_range("R4 latency", n, 2 * d + 3, 3 * d + 2);
      pin = 1'b0;
      step(4 * d);
      pulse("R3 divided", 2 * d - 1, d);
      pulse("R3 divided", 2 * d, d);
      pulse("R3 divided", 3 * d, d);
      pulse("R3 divided", 3 * d + 1, d);
    end

    // R5 rate change alone is silent
    clear_counts();
    rate = 2'd1;
    step(4 * DA);
    check("R5 quiet rise", n_rise, 0);
    check("R5 quiet fall", n_fall, 0);
    check("R5 quiet level", int'(level), 0);

    // R5 rate change and pin change in the same cycle
    rate = 2'd2;
    pin = 1'b1;
    step(3 * DB);
    check("R5 restart early", int'(level), 0);
    step(1);
    check("R5 restart exact", int'(level), 1);
    check("R5 restart rise", int'(rise), 1);
    step(1);
    check("R6 rise width div", int'(rise), 0);

    check("R8 coincidence", n_bad, 0);
    finish_run();
  end
endmodule